// File: doc/BRIEF.md
# ADC Sample Queue with DMA Request Generation

This block sits between an analog-to-digital converter core and the system bus. Each conversion result arrives with a one-cycle valid strobe and is stored in a four-entry first-in first-out queue. The host reads results through a data read port. Every read removes the oldest entry, so a read is also a pop. Status outputs report how full the queue is and whether it has been overrun or underrun. Both error flags stay set until software issues a flush command and then enables the interface again.

To move samples without the CPU, the block raises a DMA request. It can arm on "queue not empty" or on "queue three-quarters full". In single mode each request covers one pop. In burst mode a request covers up to three pops, so a burst never drains more samples than the queue held. A DMA-complete pulse, a new overflow and a new underflow each set an event latch. Each latch stays set until software clears it, and the combined interrupt is the OR of the three latches.

The control commands arrive on a small command port. Code 1 enables the interface, code 2 disables it, code 3 flushes the queue, and code 0 does nothing.

Top module: `adc_sample_queue`

## Requirements
- R1: The queue holds four samples. `st_count` gives the fill level. `st_empty` is 1 when the count is 0, `st_afull` is 1 when the count is 3 or more, and `st_full` is 1 when the count is 4. After reset the count is 0, and the interface is disabled with no errors, no events and no request.
- R2: `rd_data` shows the oldest sample in the same cycle as `rd_en`, and that sample is removed at the clock edge. A read of an empty queue returns 0, changes nothing in the queue and sets the sticky underflow flag `st_unf`.
- R3: A push accepted while the queue is full, with no pop in the same cycle, drops the incoming sample and sets the sticky overflow flag `st_ovf`. The flag stays set until a flush.
- R4: When `cmd_code`=3 is given with `cmd_valid`, the next cycle shows an empty queue, cleared error flags and a disabled interface. Samples are then taken only after `cmd_code`=1. `cmd_code`=2 disables the interface.
- R5: While the interface is disabled, or while either error flag is set, samples on `smp_valid` are ignored and the count is unchanged.
- R6: A push and a pop in the same cycle, on a queue that is neither empty nor full, leave the count unchanged and raise no error.
- R7: `dma_req` can rise only when `cfg_dma_en` is 1, the interface is enabled and no error flag is set. With `cfg_trig_afull`=0 the arming condition is count ≥ 1. With `cfg_trig_afull`=1 it is count ≥ 3. A request that is already pending is dropped one cycle after any of these conditions fails, and it is also dropped on a flush.
- R8: The number of pops a request covers is fixed when it is armed. With `cfg_burst`=0 the number is 1. With `cfg_burst`=1 it is min(count, 3). `dma_req` goes low in the cycle after the last of those pops.
- R9: `ev_flags` has three bits. Bit 0 is set by a `dma_done` pulse. Bit 1 is set when the underflow flag goes from 0 to 1. Bit 2 is set when the overflow flag goes from 0 to 1. Each bit stays set until the matching `ev_clr` bit is applied; if a set and a clear come in the same cycle, the set wins. `irq` is the OR of the three bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Converter result strobe |
| smp_data | input | DW | Converter result |
| rd_en | input | 1 | Data register read; pops the oldest sample |
| rd_data | output | DW | Oldest sample, or 0 when empty |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | 0 none, 1 enable, 2 disable, 3 flush |
| cfg_dma_en | input | 1 | Allow DMA requests |
| cfg_trig_afull | input | 1 | 0: arm on not-empty, 1: arm on three-quarters full |
| cfg_burst | input | 1 | 0: single request, 1: burst request |
| dma_done | input | 1 | DMA-complete pulse |
| dma_req | output | 1 | DMA request |
| ev_clr | input | 3 | Per-bit event clear |
| ev_flags | output | 3 | Latched events {overflow, underflow, done} |
| irq | output | 1 | OR of the event latches |
| st_count | output | CW | Fill count |
| st_empty | output | 1 | Queue empty |
| st_afull | output | 1 | Three or more entries |
| st_full | output | 1 | Four entries |
| st_ovf | output | 1 | Sticky overflow |
| st_unf | output | 1 | Sticky underflow |

## Verification
Directed sequences cover the following cases:
- filling from empty to full, then one push more, which tells a dropped sample apart from one that overwrites an entry;
- draining past empty, which checks the zero read data and the underflow latch;
- a flush followed by pushes before and after re-enable, which separates "cleared" from "ready";
- simultaneous push and pop at a middle fill level, which checks that the count holds;
- DMA runs in single and burst mode under both arming conditions, which check the exact cycle in which the request falls.

After these, long random runs with a fixed seed mix strobes, reads, commands, DMA-done pulses and event clears. They compare every output in every cycle with a cycle-level model of the queue, the error flags, the request counter and the event latches. This shows up ordering faults that the directed sequences do not reach.

// File: rtl/adcq_pkg.sv
package adcq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP     = 2'd0,
        CMD_ENABLE  = 2'd1,
        CMD_DISABLE = 2'd2,
        CMD_FLUSH   = 2'd3
    } adcq_cmd_e;

    localparam int EV_W    = 3;
    localparam int EV_DONE = 0;
    localparam int EV_UNF  = 1;
    localparam int EV_OVF  = 2;

    typedef struct packed {
        logic empty;
        logic afull;
        logic full;
    } fill_flags_t;

    typedef struct packed {
        logic drop;   // push refused because the queue was full
        logic under;  // pop attempted on an empty queue
    } fifo_err_t;

endpackage

// File: rtl/adcq_fifo.sv
module adcq_fifo
    import adcq_pkg::*;
#(
    parameter int DW    = 12,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          pop_ok,
    output logic [CW-1:0] count,
    output fill_flags_t   fill,
    output fifo_err_t     err
);
    localparam int AF_LVL = (DEPTH * 3) / 4;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic          push_ok;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        fill.empty = (count == '0);
        fill.full  = (count == CW'(DEPTH));
        fill.afull = (count >= CW'(AF_LVL));
        pop_ok     = pop && !fill.empty;
        push_ok    = push && (!fill.full || pop_ok);
        err.drop   = push && !push_ok;
        err.under  = pop && fill.empty;
        head       = fill.empty ? '0 : mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    assert_pushpop_steady_R6: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !fill.empty && !fill.full && !flush) |=> (count == $past(count)));

    assert_flush_empties_R4: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));

endmodule

// File: rtl/adcq_ctrl.sv
module adcq_ctrl
    import adcq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_valid,
    input  adcq_cmd_e cmd,
    input  fifo_err_t fifo_err,
    output logic      flush,
    output logic      enabled,
    output logic      ovf,
    output logic      unf,
    output logic      ovf_rise,
    output logic      unf_rise
);
    always_comb begin
        flush    = cmd_valid && (cmd == CMD_FLUSH);
        ovf_rise = !flush && fifo_err.drop && !ovf;
        unf_rise = !flush && fifo_err.under && !unf;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            enabled <= 1'b0;
            ovf     <= 1'b0;
            unf     <= 1'b0;
        end else begin
            ovf <= ovf | fifo_err.drop;
            unf <= unf | fifo_err.under;
            if (cmd_valid && cmd == CMD_ENABLE)       enabled <= 1'b1;
            else if (cmd_valid && cmd == CMD_DISABLE) enabled <= 1'b0;
        end
    end

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (ovf && !flush) |=> ovf);

    assert_flush_recovers_R4: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!ovf && !unf && !enabled));

endmodule

// File: rtl/adcq_dma.sv
module adcq_dma #(
    parameter int CW        = 3,
    parameter int BURST_MAX = 3,
    localparam int RW       = $clog2(BURST_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          dma_en,
    input  logic          trig_afull,
    input  logic          burst,
    input  logic          enabled,
    input  logic          err,
    input  logic [CW-1:0] count,
    input  logic          empty,
    input  logic          afull,
    input  logic          pop_ok,
    output logic          req
);
    logic [RW-1:0] remain;
    logic [RW-1:0] xfer_len;
    logic          allowed;
    logic          arm;

    always_comb begin
        allowed = dma_en && enabled && !err;
        arm     = allowed && (trig_afull ? afull : !empty);
        if (!burst)                          xfer_len = RW'(1);
        else if (count >= CW'(BURST_MAX))    xfer_len = RW'(BURST_MAX);
        else                                 xfer_len = RW'(count);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            req    <= 1'b0;
            remain <= '0;
        end else if (req) begin
            if (!allowed) begin
                req <= 1'b0;
            end else if (pop_ok) begin
                if (remain == RW'(1)) req <= 1'b0;
                remain <= remain - RW'(1);
            end
        end else if (arm) begin
            req    <= 1'b1;
            remain <= xfer_len;
        end
    end

    assert_req_blocked_R7: assert property (@(posedge clk) disable iff (rst)
        (!enabled || err) |=> !req);

    assert_req_release_R8: assert property (@(posedge clk) disable iff (rst)
        (req && pop_ok && remain == RW'(1)) |=> !req);

endmodule

// File: rtl/adcq_events.sv
module adcq_events
    import adcq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [EV_W-1:0] set,
    input  logic [EV_W-1:0] clr,
    output logic [EV_W-1:0] flags,
    output logic            irq
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr) | set;
    end

    assign irq = |flags;

    assert_event_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (flags != '0) |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));

endmodule

// File: rtl/adc_sample_queue.sv
module adc_sample_queue
    import adcq_pkg::*;
#(
    parameter int DW    = 12,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_code,
    input  logic          cfg_dma_en,
    input  logic          cfg_trig_afull,
    input  logic          cfg_burst,
    input  logic          dma_done,
    output logic          dma_req,
    input  logic [2:0]    ev_clr,
    output logic [2:0]    ev_flags,
    output logic          irq,
    output logic [CW-1:0] st_count,
    output logic          st_empty,
    output logic          st_afull,
    output logic          st_full,
    output logic          st_ovf,
    output logic          st_unf
);
    localparam int BURST_MAX = DEPTH - 1;

    fill_flags_t     fill;
    fifo_err_t       fifo_err;
    logic            flush, enabled, ovf, unf, ovf_rise, unf_rise;
    logic            push, pop_ok;
    logic [EV_W-1:0] ev_set;

    assign push = smp_valid && enabled && !ovf && !unf;

    adcq_ctrl i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (adcq_cmd_e'(cmd_code)),
        .fifo_err  (fifo_err),
        .flush     (flush),
        .enabled   (enabled),
        .ovf       (ovf),
        .unf       (unf),
        .ovf_rise  (ovf_rise),
        .unf_rise  (unf_rise)
    );

    adcq_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (push),
        .push_data (smp_data),
        .pop       (rd_en),
        .head      (rd_data),
        .pop_ok    (pop_ok),
        .count     (st_count),
        .fill      (fill),
        .err       (fifo_err)
    );

    adcq_dma #(.CW(CW), .BURST_MAX(BURST_MAX)) i_dma (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .dma_en     (cfg_dma_en),
        .trig_afull (cfg_trig_afull),
        .burst      (cfg_burst),
        .enabled    (enabled),
        .err        (ovf || unf),
        .count      (st_count),
        .empty      (fill.empty),
        .afull      (fill.afull),
        .pop_ok     (pop_ok),
        .req        (dma_req)
    );

    always_comb begin
        ev_set          = '0;
        ev_set[EV_DONE] = dma_done;
        ev_set[EV_UNF]  = unf_rise;
        ev_set[EV_OVF]  = ovf_rise;
    end

    adcq_events i_events (
        .clk   (clk),
        .rst   (rst),
        .set   (ev_set),
        .clr   (ev_clr),
        .flags (ev_flags),
        .irq   (irq)
    );

    assign st_empty = fill.empty;
    assign st_afull = fill.afull;
    assign st_full  = fill.full;
    assign st_ovf   = ovf;
    assign st_unf   = unf;

    assert_no_overflow_push_R5: assert property (@(posedge clk) disable iff (rst)
        (ovf && !flush && !rd_en) |=> (st_count == $past(st_count)));

endmodule

// File: tb/test_adc_sample_queue.sv
module test_adc_sample_queue;
    localparam int DW = 12;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid = 0, rd_en = 0, cmd_valid = 0, dma_done = 0;
    logic [DW-1:0] smp_data = '0;
    logic [1:0]    cmd_code = '0;
    logic          cfg_dma_en = 0, cfg_trig_afull = 0, cfg_burst = 0;
    logic [2:0]    ev_clr = '0;
    logic [DW-1:0] rd_data;
    logic          dma_req, irq, st_empty, st_afull, st_full, st_ovf, st_unf;
    logic [2:0]    ev_flags;
    logic [CW-1:0] st_count;

    int checks = 0, fails = 0;
    bit finished = 0;

    // bench model
    logic [DW-1:0] mq [4];
    int  mcnt = 0, mrem = 0;
    bit  movf = 0, munf = 0, men = 0, mreq = 0;
    logic [2:0] mev = '0;

    always #10 clk = ~clk;

    adc_sample_queue i_adc_sample_queue (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .rd_en(rd_en), .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cfg_dma_en(cfg_dma_en), .cfg_trig_afull(cfg_trig_afull), .cfg_burst(cfg_burst),
        .dma_done(dma_done), .dma_req(dma_req), .ev_clr(ev_clr), .ev_flags(ev_flags),
        .irq(irq), .st_count(st_count), .st_empty(st_empty), .st_afull(st_afull),
        .st_full(st_full), .st_ovf(st_ovf), .st_unf(st_unf)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_head();
        return (mcnt > 0) ? int'(mq[0]) : 0;
    endfunction

    task automatic model_step(input bit sv, input logic [DW-1:0] sd, input bit rd,
                              input bit cv, input logic [1:0] cc, input bit done,
                              input logic [2:0] clr);
        bit err, popok, unfs, ptry, pok, ovfs, ovfr, unfr;
        ovfr = 0; unfr = 0;
        if (cv && cc == 2'd3) begin
            mcnt = 0; movf = 0; munf = 0; men = 0; mreq = 0; mrem = 0;
        end else begin
            err   = movf || munf;
            popok = rd && mcnt > 0;
            unfs  = rd && mcnt == 0;
            ptry  = sv && men && !err;
            pok   = ptry && (mcnt < 4 || popok);
            ovfs  = ptry && !pok;
            if (mreq) begin
                if (!men || err || !cfg_dma_en) mreq = 0;
                else if (popok) begin
                    if (mrem == 1) mreq = 0;
                    mrem--;
                end
            end else if (cfg_dma_en && men && !err &&
                         (cfg_trig_afull ? mcnt >= 3 : mcnt >= 1)) begin
                mreq = 1;
                mrem = cfg_burst ? ((mcnt > 3) ? 3 : mcnt) : 1;
            end
            if (popok) begin
                for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
                mcnt--;
            end
            if (pok) begin
                mq[mcnt] = sd;
                mcnt++;
            end
            ovfr = ovfs && !movf;
            unfr = unfs && !munf;
            movf = movf | ovfs;
            munf = munf | unfs;
            if (cv && cc == 2'd1) men = 1;
            else if (cv && cc == 2'd2) men = 0;
        end
        mev = (mev & ~clr) | {ovfr, unfr, done};
    endtask

    task automatic compare_all();
        chk(int'(st_count) == mcnt, "R1", "count", int'(st_count), mcnt);
        chk(st_empty == (mcnt == 0), "R1", "empty", st_empty, mcnt == 0);
        chk(st_afull == (mcnt >= 3), "R1", "afull", st_afull, mcnt >= 3);
        chk(st_full == (mcnt == 4), "R1", "full", st_full, mcnt == 4);
        chk(st_ovf == movf, "R3", "ovf", st_ovf, movf);
        chk(st_unf == munf, "R2", "unf", st_unf, munf);
        chk(dma_req == mreq, "R8", "dma_req", dma_req, mreq);
        chk(ev_flags == mev, "R9", "ev_flags", int'(ev_flags), int'(mev));
        chk(irq == (mev != 0), "R9", "irq", irq, mev != 0);
    endtask

    task automatic cyc(input bit sv, input logic [DW-1:0] sd, input bit rd,
                       input bit cv, input logic [1:0] cc, input bit done,
                       input logic [2:0] clr);
        smp_valid = sv; smp_data = sd; rd_en = rd;
        cmd_valid = cv; cmd_code = cc; dma_done = done; ev_clr = clr;
        #1;
        if (rd) chk(int'(rd_data) == exp_head(), "R2", "rd_data", int'(rd_data), exp_head());
        @(posedge clk);
        model_step(sv, sd, rd, cv, cc, done, clr);
        @(negedge clk);
        compare_all();
    endtask

    task automatic push(input logic [DW-1:0] d); cyc(1, d, 0, 0, 0, 0, 0); endtask
    task automatic pop();                        cyc(0, 0, 1, 0, 0, 0, 0); endtask
    task automatic cmd(input logic [1:0] c);     cyc(0, 0, 0, 1, c, 0, 0); endtask
    task automatic idle();                       cyc(0, 0, 0, 0, 0, 0, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        compare_all(); // R1 reset state
        chk(dma_req == 0 && irq == 0, "R1", "reset req/irq", dma_req | irq, 0);

        push(12'h111);                                  // disabled: ignored
        chk(st_count == 0, "R5", "push while disabled", int'(st_count), 0);
        cmd(2'd1);
        push(12'hA01); push(12'hA02); push(12'hA03); push(12'hA04);
        chk(st_full == 1, "R1", "full at four", st_full, 1);
        push(12'hA05);                                  // overflow
        chk(st_ovf == 1 && ev_flags[2] == 1, "R3", "overflow latch", st_ovf, 1);
        pop();
        push(12'hA06);                                  // error gates push
        chk(st_count == 3, "R5", "push during error", int'(st_count), 3);
        pop(); pop(); pop();
        pop();                                          // empty read
        chk(st_unf == 1 && ev_flags[1] == 1, "R2", "underflow latch", st_unf, 1);
        cyc(0, 0, 0, 0, 0, 0, 3'b111);
        chk(ev_flags == 0, "R9", "event clear", int'(ev_flags), 0);
        cmd(2'd3);
        chk(st_ovf == 0 && st_unf == 0, "R4", "flush clears errors", st_ovf | st_unf, 0);
        push(12'hB01);
        chk(st_count == 0, "R4", "no push before re-enable", int'(st_count), 0);
        cmd(2'd1);
        push(12'hB02); push(12'hB03);
        cyc(1, 12'hB04, 1, 0, 0, 0, 0);
        chk(st_count == 2, "R6", "push+pop count steady", int'(st_count), 2);
        pop(); pop();

        // DMA burst on three-quarters full (R7, R8)
        cfg_dma_en = 1; cfg_trig_afull = 1; cfg_burst = 1;
        push(12'hC01); push(12'hC02);
        chk(dma_req == 0, "R7", "no req below three", dma_req, 0);
        push(12'hC03);
        idle();
        chk(dma_req == 1, "R7", "req at three", dma_req, 1);
        pop(); pop();
        chk(dma_req == 1, "R8", "burst still pending", dma_req, 1);
        pop();
        chk(dma_req == 0, "R8", "burst released", dma_req, 0);
        // single on not-empty
        cfg_trig_afull = 0; cfg_burst = 0;
        push(12'hD01); push(12'hD02);
        chk(dma_req == 1, "R7", "single req armed", dma_req, 1);
        pop();
        chk(dma_req == 0, "R8", "single released", dma_req, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk(ev_flags[0] == 1 && irq == 1, "R9", "done event", ev_flags[0], 1);
        cmd(2'd2);
        idle();
        chk(dma_req == 0, "R7", "req dropped when disabled", dma_req, 0);

        // random phase
        for (int n = 0; n < 6000; n++) begin
            bit sv, rd, cv, dn;
            logic [1:0] cc;
            int r;
            if (n % 300 == 0) begin
                cfg_dma_en = ($urandom % 4) != 0;
                cfg_trig_afull = $urandom % 2;
                cfg_burst = $urandom % 2;
            end
            sv = ($urandom % 2) == 0;
            rd = ($urandom % 3) == 0;
            if (dma_req && ($urandom % 2)) rd = 1;
            cv = ($urandom % 12) == 0;
            r = $urandom % 10;
            cc = (r < 5) ? 2'd1 : (r < 7) ? 2'd2 : (r < 9) ? 2'd3 : 2'd0;
            dn = ($urandom % 20) == 0;
            cyc(sv, DW'($urandom), rd, cv, cc, dn, 3'($urandom % 8 == 0 ? $urandom : 0));
        end

        finished = 1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule